// File: doc/BRIEF.md
# Shared Word and Byte Memory Front End

This block owns a single RAM organised as 32-bit words and offers two views of it. A word port, addressed by a word index, reads a whole word into a data register or writes one from a write-data input. A separate byte port, addressed by a byte index, is read-only. It returns one byte into a byte register for use as an instruction stream. Both views refer to the same storage. The byte view numbers bytes little-endian: byte address 4k+i is lane i of word k, and lane 0 is the least significant byte.

A microcoded controller drives three request strobes: word read, word write and byte fetch. It assumes a fixed latency. A request sampled at one clock edge has its data registered at the following edge. The data can therefore be used two microinstructions after the one that issued it. A word write and a byte fetch may happen in the same cycle. A fetch of the word being written sees the contents from before the write. Raising word read and word write together is a controller error. The write wins, the read is dropped, and an error flag pulses for one cycle. A parameter chooses whether reset also clears the whole RAM.

Top module: `wbm_front`

## Requirements
- R1: While reset is held and in the first cycle after it, word_rdata, byte_rdata, word_rvalid, byte_rvalid and clash_err are all 0.
- R2: A word read sampled at edge E returns the word most recently written at word_addr on word_rdata after edge E+1, with word_rvalid high for exactly the one cycle after E+1.
- R3: A byte fetch sampled at edge E returns bits [8i+7:8i] of word byte_addr[AW+1:2], where i = byte_addr[1:0] (little-endian lanes), on byte_rdata after edge E+1, with byte_rvalid high for exactly that one cycle.
- R4: In the cycle between edges E and E+1, word_rdata and byte_rdata still show their previous values and both valid flags are 0 for a request sampled at E.
- R5: When no read is delivered, word_rdata and byte_rdata hold their last values.
- R6: A byte fetch sampled at the same edge as a word write to the same word returns the byte from before the write. A later fetch returns the new byte.
- R7: When word read and word write are sampled together, the write is performed, no read data is delivered (word_rvalid stays 0, word_rdata unchanged), and clash_err is high for exactly the one cycle after that edge.
- R8: With CLEAR_ON_RST = 1, every word reads as 0 after a reset, including after a reset that follows writes.
- R9: A word read and a byte fetch sampled at the same edge are both served with the latency of R2 and R3, each returning its own address's data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_req | input | 1 | Word read request |
| wr_req | input | 1 | Word write request |
| fetch_req | input | 1 | Byte fetch request |
| word_addr | input | WORD_AW | Word index for read or write |
| word_wdata | input | 32 | Write data for the word port |
| byte_addr | input | WORD_AW+2 | Byte index for fetch |
| word_rdata | output | 32 | Word read data register |
| word_rvalid | output | 1 | Word read data delivered this cycle |
| byte_rdata | output | 8 | Fetched byte register |
| byte_rvalid | output | 1 | Fetched byte delivered this cycle |
| clash_err | output | 1 | Pulse after a simultaneous read and write |

## Verification
The bench builds the block with WORD_AW = 4 and CLEAR_ON_RST = 1. With 16 words and 64 byte addresses, every word and every byte lane can be written, read and fetched with values computed arithmetically. This covers the full lane mapping, same-cycle write-and-fetch on every word, and clear-after-reset across the whole array. Each request is followed through both edges of its latency, so early delivery and failure to hold the outputs are both observed.

// File: rtl/wbm_pkg.sv
// Shared constants and helpers for the word/byte memory front end.
// Assumes a 32-bit word split into four little-endian byte lanes.
package wbm_pkg;
    localparam int WORD_W = 32;
    localparam int BYTE_W = 8;
    localparam int LANES  = WORD_W / BYTE_W;
    localparam int LANE_W = $clog2(LANES);

    // Resolved command after arbitration of the raw strobes.
    typedef struct packed {
        logic rd;
        logic wr;
        logic fetch;
    } wbm_cmd_t;

    // Extract lane `lane` of a word, lane 0 being the least significant byte.
    function automatic logic [BYTE_W-1:0] lane_byte(input logic [WORD_W-1:0] w,
                                                    input logic [LANE_W-1:0] lane);
        return w[lane*BYTE_W +: BYTE_W];
    endfunction
endpackage

// File: rtl/wbm_arbiter.sv
// Resolves the raw request strobes into the command actually carried out.
// Assumes rd and wr together is a controller error: the write wins and a
// one-cycle error pulse is raised after the offending edge.
module wbm_arbiter
    import wbm_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     rd_in,
    input  logic     wr_in,
    input  logic     fetch_in,
    output wbm_cmd_t cmd,
    output logic     clash
);
    // Write priority over read; fetch is independent.
    always_comb begin
        cmd.wr    = wr_in;
        cmd.rd    = rd_in & ~wr_in;
        cmd.fetch = fetch_in;
    end

    // Register the clash indication so it pulses for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) clash <= 1'b0;
        else        clash <= rd_in & wr_in;
    end
endmodule

// File: rtl/wbm_store.sv
// Word-organised RAM with one write port and two registered read ports.
// Assumes reads return the contents from before a write at the same edge.
// CLEAR_ON_RST selects whether synchronous reset zeroes the whole array.
module wbm_store
    import wbm_pkg::*;
#(
    parameter int AW           = 6,
    parameter bit CLEAR_ON_RST = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [AW-1:0]     rd_idx,
    input  logic              fetch_en,
    input  logic [AW-1:0]     fetch_idx,
    output logic [WORD_W-1:0] rd_q,
    output logic              rd_q_vld,
    output logic [WORD_W-1:0] fetch_q,
    output logic              fetch_q_vld
);
    localparam int DEPTH = 1 << AW;

    logic [WORD_W-1:0] mem [DEPTH];

    generate
        if (CLEAR_ON_RST) begin : g_clear
            // Array write, with the whole array cleared during reset.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
                end else if (wr_en) begin
                    mem[wr_idx] <= wr_data;
                end
            end
        end else begin : g_keep
            // Array write; contents survive reset.
            always_ff @(posedge clk) begin
                if (wr_en) mem[wr_idx] <= wr_data;
            end
        end
    endgenerate

    // First pipeline stage of the word read port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q     <= '0;
            rd_q_vld <= 1'b0;
        end else begin
            rd_q_vld <= rd_en;
            if (rd_en) rd_q <= mem[rd_idx];
        end
    end

    // First pipeline stage of the byte fetch port (whole word).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_q     <= '0;
            fetch_q_vld <= 1'b0;
        end else begin
            fetch_q_vld <= fetch_en;
            if (fetch_en) fetch_q <= mem[fetch_idx];
        end
    end
endmodule

// File: rtl/wbm_lane_pick.sv
// Second stage of the fetch path: remembers the requested lane and drops the
// chosen byte of the stage-one word into the byte output register.
// Assumes stage one delivers the word one edge after the request.
module wbm_lane_pick
    import wbm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [LANE_W-1:0] lane_in,
    input  logic [WORD_W-1:0] word_in,
    input  logic              word_vld,
    output logic [BYTE_W-1:0] byte_out,
    output logic              byte_vld
);
    logic [LANE_W-1:0] lane_q;

    // Carry the lane alongside the word read from the array.
    always_ff @(posedge clk) begin
        if (!rst_n)   lane_q <= '0;
        else if (req) lane_q <= lane_in;
    end

    // Load the selected byte; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_out <= '0;
            byte_vld <= 1'b0;
        end else begin
            byte_vld <= word_vld;
            if (word_vld) byte_out <= lane_byte(word_in, lane_q);
        end
    end
endmodule

// File: rtl/wbm_word_out.sv
// Second stage of the word read path: loads the data register when stage
// one has a word and holds it otherwise.
module wbm_word_out
    import wbm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word_in,
    input  logic              word_vld,
    output logic [WORD_W-1:0] word_out,
    output logic              out_vld
);
    // Output register with hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_out <= '0;
            out_vld  <= 1'b0;
        end else begin
            out_vld <= word_vld;
            if (word_vld) word_out <= word_in;
        end
    end
endmodule

// File: rtl/wbm_front.sv
// Top of the word/byte memory front end. One word RAM is seen word-addressed
// on the word port and byte-addressed (little-endian lanes) on the read-only
// fetch port. Read data lands in the output registers two edges after the
// request edge. Assumes a synchronous active-low reset.
module wbm_front
    import wbm_pkg::*;
#(
    parameter int WORD_AW      = 6,
    parameter bit CLEAR_ON_RST = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_req,
    input  logic                 wr_req,
    input  logic                 fetch_req,
    input  logic [WORD_AW-1:0]   word_addr,
    input  logic [31:0]          word_wdata,
    input  logic [WORD_AW+1:0]   byte_addr,
    output logic [31:0]          word_rdata,
    output logic                 word_rvalid,
    output logic [7:0]           byte_rdata,
    output logic                 byte_rvalid,
    output logic                 clash_err
);
    localparam int BAW = WORD_AW + LANE_W;

    wbm_cmd_t          cmd;
    logic [WORD_W-1:0] rd_q, fetch_q;
    logic              rd_q_vld, fetch_q_vld;
    logic [WORD_AW-1:0] fetch_idx;
    logic [LANE_W-1:0]  fetch_lane;

    // Split the byte address into word index and lane.
    assign fetch_idx  = byte_addr[BAW-1:LANE_W];
    assign fetch_lane = byte_addr[LANE_W-1:0];

    wbm_arbiter u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_in    (rd_req),
        .wr_in    (wr_req),
        .fetch_in (fetch_req),
        .cmd      (cmd),
        .clash    (clash_err)
    );

    wbm_store #(.AW(WORD_AW), .CLEAR_ON_RST(CLEAR_ON_RST)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (cmd.wr),
        .wr_idx      (word_addr),
        .wr_data     (word_wdata),
        .rd_en       (cmd.rd),
        .rd_idx      (word_addr),
        .fetch_en    (cmd.fetch),
        .fetch_idx   (fetch_idx),
        .rd_q        (rd_q),
        .rd_q_vld    (rd_q_vld),
        .fetch_q     (fetch_q),
        .fetch_q_vld (fetch_q_vld)
    );

    wbm_word_out u_wout (
        .clk      (clk),
        .rst_n    (rst_n),
        .word_in  (rd_q),
        .word_vld (rd_q_vld),
        .word_out (word_rdata),
        .out_vld  (word_rvalid)
    );

    wbm_lane_pick u_lane (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (cmd.fetch),
        .lane_in  (fetch_lane),
        .word_in  (fetch_q),
        .word_vld (fetch_q_vld),
        .byte_out (byte_rdata),
        .byte_vld (byte_rvalid)
    );

    // Word data is delivered only two edges after a non-clashing read.
    p_word_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        word_rvalid |-> $past(rd_req && !wr_req, 2));

    // Byte data is delivered only two edges after a fetch.
    p_byte_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        byte_rvalid |-> $past(fetch_req, 2));

    // A clashing read never produces word data.
    p_clash_drops_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clash_err |=> !word_rvalid);

    // Word data register holds when nothing is delivered.
    p_word_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !word_rvalid |-> $stable(word_rdata));

    // Byte data register holds when nothing is delivered.
    p_byte_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_rvalid |-> $stable(byte_rdata));
endmodule

// File: tb/tb_wbm_front.sv
`timescale 1ns/1ps
module tb_wbm_front;
    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;
    localparam int NB    = DEPTH * 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_req = 0, wr_req = 0, fetch_req = 0;
    logic [AW-1:0] word_addr = '0;
    logic [31:0]   word_wdata = '0;
    logic [AW+1:0] byte_addr = '0;
    logic [31:0]   word_rdata;
    logic          word_rvalid;
    logic [7:0]    byte_rdata;
    logic          byte_rvalid;
    logic          clash_err;

    int vectors = 0;
    int fails   = 0;
    bit done    = 0;
    logic [31:0] model [DEPTH];
    logic [31:0] last_word;
    logic [7:0]  last_byte;

    always #2.5 clk = ~clk;

    wbm_front #(.WORD_AW(AW), .CLEAR_ON_RST(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .wr_req(wr_req),
        .fetch_req(fetch_req), .word_addr(word_addr), .word_wdata(word_wdata),
        .byte_addr(byte_addr), .word_rdata(word_rdata), .word_rvalid(word_rvalid),
        .byte_rdata(byte_rdata), .byte_rvalid(byte_rvalid), .clash_err(clash_err)
    );

    function automatic logic [31:0] pat(input int k, input int salt);
        return (32'h9E37_79B9 * (k + 1 + salt)) ^ (32'(k) << 20) ^ 32'(salt * 7);
    endfunction

    function automatic logic [7:0] byte_of(input int b);
        return model[b >> 2][(b & 3) * 8 +: 8];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one request at a negedge; return at the negedge after edge E.
    task automatic issue(input logic r, input logic w, input logic f,
                         input int wa, input logic [31:0] wd, input int ba);
        rd_req = r; wr_req = w; fetch_req = f;
        word_addr = AW'(wa); word_wdata = wd; byte_addr = (AW+2)'(ba);
        @(posedge clk); @(negedge clk);
        rd_req = 0; wr_req = 0; fetch_req = 0;
    endtask

    task automatic next_cycle();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic read_word(input int k, input string req);
        issue(1, 0, 0, k, '0, 0);
        chk("R4", {31'd0, word_rvalid}, 32'd0);
        chk("R4", word_rdata, last_word);
        next_cycle();
        chk(req, word_rdata, model[k]);
        chk(req, {31'd0, word_rvalid}, 32'd1);
        last_word = model[k];
        next_cycle();
        chk("R5", {31'd0, word_rvalid}, 32'd0);
        chk("R5", word_rdata, last_word);
    endtask

    task automatic fetch_byte(input int b, input string req);
        issue(0, 0, 1, 0, '0, b);
        chk("R4", {31'd0, byte_rvalid}, 32'd0);
        chk("R4", {24'd0, byte_rdata}, {24'd0, last_byte});
        next_cycle();
        chk(req, {24'd0, byte_rdata}, {24'd0, byte_of(b)});
        chk(req, {31'd0, byte_rvalid}, 32'd1);
        last_byte = byte_of(b);
        next_cycle();
        chk("R5", {31'd0, byte_rvalid}, 32'd0);
        chk("R5", {24'd0, byte_rdata}, {24'd0, last_byte});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < DEPTH; k++) model[k] = '0;
        last_word = '0; last_byte = '0;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", word_rdata, 32'd0);
        chk("R1", {24'd0, byte_rdata}, 32'd0);
        chk("R1", {31'd0, word_rvalid}, 32'd0);
        chk("R1", {31'd0, byte_rvalid}, 32'd0);
        chk("R1", {31'd0, clash_err}, 32'd0);
        rst_n = 1'b1;
        next_cycle();
        chk("R1", {29'd0, word_rvalid, byte_rvalid, clash_err}, 32'd0);

        // R8: array reads zero after reset
        for (int k = 0; k < DEPTH; k++) read_word(k, "R8");

        // Fill every word
        for (int k = 0; k < DEPTH; k++) begin
            model[k] = pat(k, 0);
            issue(0, 1, 0, k, model[k], 0);
            chk("R7", {31'd0, clash_err}, 32'd0);
        end
        next_cycle();

        // R2: every word read back
        for (int k = 0; k < DEPTH; k++) read_word(k, "R2");

        // R3: every byte address, little-endian lanes
        for (int b = 0; b < NB; b++) fetch_byte(b, "R3");

        // R9: word read and byte fetch together
        for (int k = 0; k < DEPTH; k++) begin
            int b;
            b = (DEPTH - 1 - k) * 4 + (k & 3);
            issue(1, 0, 1, k, '0, b);
            next_cycle();
            chk("R9", word_rdata, model[k]);
            chk("R9", {24'd0, byte_rdata}, {24'd0, byte_of(b)});
            chk("R9", {30'd0, word_rvalid, byte_rvalid}, 32'd3);
            last_word = model[k]; last_byte = byte_of(b);
        end
        next_cycle();

        // R6: write plus fetch of the same word returns old byte
        for (int k = 0; k < DEPTH; k++) begin
            int b;
            logic [7:0] old_b;
            b = k * 4 + ((k + 1) & 3);
            old_b = byte_of(b);
            issue(0, 1, 1, k, pat(k, 5), b);
            model[k] = pat(k, 5);
            next_cycle();
            chk("R6", {24'd0, byte_rdata}, {24'd0, old_b});
            last_byte = old_b;
            next_cycle();
            fetch_byte(b, "R6");
        end

        // R7: read and write together
        issue(1, 1, 0, 3, 32'hC0DE_F00D, 0);
        model[3] = 32'hC0DE_F00D;
        chk("R7", {31'd0, clash_err}, 32'd1);
        chk("R7", {31'd0, word_rvalid}, 32'd0);
        next_cycle();
        chk("R7", {31'd0, clash_err}, 32'd0);
        chk("R7", {31'd0, word_rvalid}, 32'd0);
        chk("R7", word_rdata, last_word);
        next_cycle();
        chk("R7", {31'd0, word_rvalid}, 32'd0);
        read_word(3, "R7");

        // R8: reset after writes clears the array
        rst_n = 1'b0;
        repeat (2) next_cycle();
        rst_n = 1'b1;
        for (int k = 0; k < DEPTH; k++) model[k] = '0;
        last_word = '0; last_byte = '0;
        next_cycle();
        for (int k = 0; k < DEPTH; k++) read_word(k, "R8");
        fetch_byte(NB - 1, "R8");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule